// File: doc/BRIEF.md
# Branch Target Buffer with Return Address Stack

This block sits beside the fetch stage of a pipelined core. Every cycle the fetch unit presents the address it is about to fetch; the block answers in the same cycle whether that address holds a known branch, which kind of branch it is, whether it is predicted taken, and which address to fetch next. Storage is a direct-mapped table. Each entry holds a valid bit, an address tag, a branch kind, a 2-bit saturating direction counter and a target address.

Return instructions rarely go to the same place twice. Their target comes from a small hardware stack instead of the table. When a lookup hits a call, the address after the call is pushed. When a lookup hits a return, the top of the stack is popped and becomes the next fetch address. When the branch later resolves in the back end, the core writes its tag, target, kind and direction into the table. A flush input discards all learned state.

Top module: `btb_ras`

## Requirements
- R1: After reset, and in every cycle after a cycle with `flush` high, every lookup misses and the return stack is empty.
- R2: A lookup that misses reports `pred_hit`=0 and `pred_taken`=0, and `pred_next` equals `lookup_pc` plus INSTR_BYTES.
- R3: The entry is chosen by `pc[OFF_W+INDEX_W-1:OFF_W]`, where OFF_W is log2(INSTR_BYTES). The tag is every bit above that field. A lookup hits only when the selected entry is valid and its tag equals the tag of the lookup address.
- R4: Branch kinds are encoded 0 = conditional, 1 = unconditional jump, 2 = call, 3 = return. When an update creates or replaces an entry, its counter starts at 2 (weakly taken) if `upd_taken`=1 and at 1 (weakly not taken) otherwise.
- R5: An update to a resident conditional entry with kind conditional moves its counter up on taken and down on not taken, saturating at 3 and 0. A conditional hit is predicted taken exactly when the counter is 2 or 3. A taken prediction gives the stored target as `pred_next`; a not-taken prediction gives the sequential address.
- R6: A hit on a jump or a call is always predicted taken, with the stored target as `pred_next`.
- R7: A hit on a call pushes `lookup_pc`+INSTR_BYTES onto the stack. A hit on a return with a non-empty stack is predicted taken, pops the stack, and gives the popped value as `pred_next`.
- R8: A hit on a return while the stack is empty is predicted taken, gives the stored target as `pred_next`, and leaves the stack unchanged.
- R9: The stack holds RAS_DEPTH entries. A push onto a full stack overwrites the oldest entry. After RAS_DEPTH+1 pushes, RAS_DEPTH pops return the newest RAS_DEPTH values, newest first, and the next return falls back to its stored target.
- R10: An update whose address maps to an entry held by another tag replaces that entry. The old branch then misses.
- R11: A lookup in the same cycle as an update to its own entry sees the contents from before the update. The new contents are visible from the next cycle.
- R12: When `flush` is high in the same cycle as an update or a call push, the flush wins. Neither the update nor the push takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clears all valid bits and empties the stack |
| lookup_valid | input | 1 | A fetch lookup is presented this cycle |
| lookup_pc | input | ADDR_W | Fetch address |
| pred_hit | output | 1 | Address is a known branch |
| pred_kind | output | 2 | Kind of the hit branch (0 when miss) |
| pred_taken | output | 1 | Branch predicted taken |
| pred_next | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is written this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Resolved target address |
| upd_taken | input | 1 | Resolved direction |
| upd_kind | input | 2 | Kind of the resolved branch |

## Verification
A lookup and a resolution update can land in the same cycle on the same entry. A flush can also coincide with an update or with a call that pushes. The bench provokes the first case with a directed step that retargets a resident entry while it is being looked up. It provokes the second with a flush that carries both an update and a call hit. Random traffic over a small address pool then makes both cases occur often. Each cycle is judged against a reference model in the bench. The model predicts from the state before the edge, then applies flush, push or pop, and update with flush taking priority.

// File: rtl/btb_ras.sv
module btb_ras #(
  parameter int ADDR_W      = 32,
  parameter int INDEX_W     = 4,
  parameter int RAS_DEPTH   = 4,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_pc,
  output logic              pred_hit,
  output logic [1:0]        pred_kind,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken,
  input  logic [1:0]        upd_kind
);
  localparam int OFF_W   = $clog2(INSTR_BYTES);
  localparam int ENTRIES = 1 << INDEX_W;
  localparam int TAG_W   = ADDR_W - INDEX_W - OFF_W;
  localparam int SP_W    = (RAS_DEPTH > 1) ? $clog2(RAS_DEPTH) : 1;
  localparam int CNT_W   = $clog2(RAS_DEPTH + 1);
  localparam logic [1:0] K_COND = 2'd0, K_JUMP = 2'd1, K_CALL = 2'd2, K_RET = 2'd3;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q  [ENTRIES];
  logic [1:0]         kind_q [ENTRIES];
  logic [1:0]         ctr_q  [ENTRIES];
  logic [ADDR_W-1:0]  ras_q  [RAS_DEPTH];
  logic [SP_W-1:0]    sp_q;
  logic [CNT_W-1:0]   cnt_q;

  wire [INDEX_W-1:0] l_idx = lookup_pc[OFF_W +: INDEX_W];
  wire [TAG_W-1:0]   l_tag = lookup_pc[ADDR_W-1 -: TAG_W];
  wire [ADDR_W-1:0]  seq_pc = lookup_pc + ADDR_W'(INSTR_BYTES);
  wire               ras_empty = (cnt_q == '0);
  wire [SP_W-1:0]    top_idx = (sp_q == '0) ? SP_W'(RAS_DEPTH - 1) : sp_q - 1'b1;
  wire [SP_W-1:0]    sp_up   = (sp_q == SP_W'(RAS_DEPTH - 1)) ? '0 : sp_q + 1'b1;

  assign pred_hit  = lookup_valid && valid_q[l_idx] && (tag_q[l_idx] == l_tag);
  assign pred_kind = pred_hit ? kind_q[l_idx] : K_COND;

  always_comb begin
    pred_taken = 1'b0;
    pred_next  = seq_pc;
    if (pred_hit) begin
      case (kind_q[l_idx])
        K_COND: pred_taken = ctr_q[l_idx][1];
        K_RET:  pred_taken = 1'b1;
        default: pred_taken = 1'b1;
      endcase
      if (pred_taken)
        pred_next = (kind_q[l_idx] == K_RET && !ras_empty) ? ras_q[top_idx] : tgt_q[l_idx];
    end
  end

  wire do_push = pred_hit && (pred_kind == K_CALL);
  wire do_pop  = pred_hit && (pred_kind == K_RET) && !ras_empty;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      sp_q  <= '0;
      cnt_q <= '0;
    end else if (do_push) begin
      ras_q[sp_q] <= seq_pc;
      sp_q        <= sp_up;
      if (cnt_q != CNT_W'(RAS_DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (do_pop) begin
      sp_q  <= top_idx;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  wire [INDEX_W-1:0] u_idx = upd_pc[OFF_W +: INDEX_W];
  wire [TAG_W-1:0]   u_tag = upd_pc[ADDR_W-1 -: TAG_W];
  wire u_train = valid_q[u_idx] && (tag_q[u_idx] == u_tag) &&
                 (kind_q[u_idx] == K_COND) && (upd_kind == K_COND);
  logic [1:0] ctr_new;

  always_comb begin
    if (!u_train)            ctr_new = upd_taken ? 2'd2 : 2'd1;
    else if (upd_taken)      ctr_new = (ctr_q[u_idx] == 2'd3) ? 2'd3 : ctr_q[u_idx] + 2'd1;
    else                     ctr_new = (ctr_q[u_idx] == 2'd0) ? 2'd0 : ctr_q[u_idx] - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) valid_q <= '0;
    else if (upd_valid)  valid_q[u_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && upd_valid) begin
      tag_q[u_idx]  <= u_tag;
      tgt_q[u_idx]  <= upd_target;
      kind_q[u_idx] <= upd_kind;
      ctr_q[u_idx]  <= ctr_new;
    end
  end
endmodule

// File: rtl/btb_ras_chk.sv
module btb_ras_chk #(
  parameter int ADDR_W    = 32,
  parameter int RAS_DEPTH = 4,
  parameter int CNT_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lookup_valid,
  input logic [ADDR_W-1:0] lookup_pc,
  input logic              pred_hit,
  input logic [1:0]        pred_kind,
  input logic              pred_taken,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_pc,
  input logic [CNT_W-1:0]  cnt_q
);
  AST_FLUSH_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) && $past(rst_n) |-> !pred_hit && cnt_q == '0); // R1
  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(RAS_DEPTH)); // R9
  AST_CALL_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    pred_hit && pred_kind == 2'd2 && !flush && cnt_q < CNT_W'(RAS_DEPTH)
    |=> cnt_q == $past(cnt_q) + 1'b1); // R7
  AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    pred_hit && pred_kind != 2'd0 |-> pred_taken); // R6
  AST_UPDATE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(upd_valid) && !$past(flush) && lookup_valid &&
    lookup_pc == $past(upd_pc) |-> pred_hit); // R11
endmodule

bind btb_ras btb_ras_chk #(.ADDR_W(ADDR_W), .RAS_DEPTH(RAS_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lookup_valid(lookup_valid),
  .lookup_pc(lookup_pc), .pred_hit(pred_hit), .pred_kind(pred_kind),
  .pred_taken(pred_taken), .upd_valid(upd_valid), .upd_pc(upd_pc), .cnt_q(cnt_q));

// File: tb/tb_btb_ras.sv
`timescale 1ns/1ps
module tb_btb_ras;
  localparam int AW = 32, IW = 4, DEPTH = 4, NE = 16;
  localparam logic [1:0] KC = 2'd0, KJ = 2'd1, KL = 2'd2, KR = 2'd3;

  logic clk = 0, rst_n = 0, flush = 0, lookup_valid = 0, upd_valid = 0, upd_taken = 0;
  logic [AW-1:0] lookup_pc = '0, upd_pc = '0, upd_target = '0;
  logic [1:0] upd_kind = '0, pred_kind;
  logic pred_hit, pred_taken;
  logic [AW-1:0] pred_next;
  int checks = 0, errors = 0;
  bit done = 0;

  btb_ras #(.ADDR_W(AW), .INDEX_W(IW), .RAS_DEPTH(DEPTH), .INSTR_BYTES(4)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lookup_valid(lookup_valid),
    .lookup_pc(lookup_pc), .pred_hit(pred_hit), .pred_kind(pred_kind),
    .pred_taken(pred_taken), .pred_next(pred_next), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken), .upd_kind(upd_kind));

  always #2.5 clk = ~clk;

  bit            m_v   [NE];
  logic [25:0]   m_tag [NE];
  logic [AW-1:0] m_tgt [NE];
  logic [1:0]    m_k   [NE];
  logic [1:0]    m_c   [NE];
  logic [AW-1:0] m_ras [DEPTH];
  int m_sp = 0, m_cnt = 0;

  function automatic logic [AW-1:0] mk(int t, int i);
    return {26'(t), 4'(i), 2'b00};
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic predict(input logic [AW-1:0] pc, output bit h, output bit tk,
                         output logic [AW-1:0] nx, output string lab);
    int i = int'(pc[5:2]);
    h = m_v[i] && m_tag[i] == pc[31:6];
    tk = 0; nx = pc + 4; lab = "R2";
    if (h) begin
      case (m_k[i])
        KC: begin tk = m_c[i][1]; lab = "R5"; end
        KR: begin tk = 1; lab = (m_cnt > 0) ? "R7" : "R8"; end
        default: begin tk = 1; lab = "R6"; end
      endcase
      if (tk) nx = (m_k[i] == KR && m_cnt > 0) ? m_ras[(m_sp + DEPTH - 1) % DEPTH] : m_tgt[i];
    end
  endtask

  task automatic step(bit lv, logic [AW-1:0] lpc, bit uv, logic [AW-1:0] upc,
                      logic [AW-1:0] utg, bit utk, logic [1:0] uk, bit fl, string tag);
    bit h, tk; logic [AW-1:0] nx; string lab;
    @(negedge clk);
    lookup_valid = lv; lookup_pc = lpc; upd_valid = uv; upd_pc = upc;
    upd_target = utg; upd_taken = utk; upd_kind = uk; flush = fl;
    #1;
    predict(lpc, h, tk, nx, lab);
    if (!lv) h = 0;
    if (tag != "") lab = tag;
    if (lv) begin
      check(lab, AW'(pred_hit), AW'(h));
      check(lab, AW'(pred_taken), AW'(h && tk));
      check(lab, pred_next, lv && h && tk ? nx : lpc + 4);
    end
    @(posedge clk);
    if (fl) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_sp = 0; m_cnt = 0;
    end else begin
      if (lv && h) begin
        int i = int'(lpc[5:2]);
        if (m_k[i] == KL) begin
          m_ras[m_sp] = lpc + 4; m_sp = (m_sp + 1) % DEPTH;
          if (m_cnt < DEPTH) m_cnt++;
        end else if (m_k[i] == KR && m_cnt > 0) begin
          m_sp = (m_sp + DEPTH - 1) % DEPTH; m_cnt--;
        end
      end
      if (uv) begin
        int i = int'(upc[5:2]);
        bit tr = m_v[i] && m_tag[i] == upc[31:6] && m_k[i] == KC && uk == KC;
        if (!tr) m_c[i] = utk ? 2'd2 : 2'd1;
        else if (utk) m_c[i] = (m_c[i] == 3) ? 2'd3 : m_c[i] + 2'd1;
        else m_c[i] = (m_c[i] == 0) ? 2'd0 : m_c[i] - 2'd1;
        m_v[i] = 1; m_tag[i] = upc[31:6]; m_tgt[i] = utg; m_k[i] = uk;
      end
    end
  endtask

  task automatic look(logic [AW-1:0] pc, string tag);
    step(1, pc, 0, '0, '0, 0, KC, 0, tag);
  endtask
  task automatic upd(logic [AW-1:0] pc, logic [AW-1:0] tg, bit tk, logic [1:0] k);
    step(0, '0, 1, pc, tg, tk, k, 0, "");
  endtask

  initial begin
    int unused_seed = $urandom(32'h5eed);
    foreach (m_v[i]) m_v[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); lookup_valid = 1; lookup_pc = mk(1, 3); #1;
    check("R1", AW'(pred_hit), 0);
    @(negedge clk); rst_n = 1;

    look(mk(1, 3), "R2");
    upd(mk(1, 3), 32'h1000, 1, KC); look(mk(1, 3), "R4");
    upd(mk(1, 4), 32'h1100, 0, KC); look(mk(1, 4), "R4");
    upd(mk(1, 3), 32'h1000, 1, KC); upd(mk(1, 3), 32'h1000, 0, KC);
    look(mk(1, 3), "R5");
    upd(mk(1, 4), 32'h1100, 0, KC); upd(mk(1, 4), 32'h1100, 0, KC);
    upd(mk(1, 4), 32'h1100, 1, KC); look(mk(1, 4), "R5");
    look(mk(2, 3), "R3");
    upd(mk(2, 3), 32'h2000, 0, KJ); look(mk(1, 3), "R10"); look(mk(2, 3), "R6");
    upd(mk(1, 7), 32'h7000, 1, KR); look(mk(1, 7), "R8");
    upd(mk(1, 8), 32'h8000, 1, KL); look(mk(1, 8), "R6"); look(mk(1, 7), "R7");
    for (int c = 0; c < DEPTH + 1; c++) upd(mk(3, 9 + c), 32'h9000 + 32'(c), 1, KL);
    for (int c = 0; c < DEPTH + 1; c++) look(mk(3, 9 + c), "R9");
    for (int c = 0; c < DEPTH + 1; c++) look(mk(1, 7), "R9");
    step(1, mk(2, 3), 1, mk(2, 3), 32'h2222, 1, KJ, 0, "R11");
    look(mk(2, 3), "R11");
    step(1, mk(1, 8), 1, mk(1, 5), 32'h5000, 1, KJ, 1, "R12");
    look(mk(1, 5), "R12"); look(mk(2, 3), "R1");
    upd(mk(1, 7), 32'h7700, 1, KR); look(mk(1, 7), "R12");

    for (int n = 0; n < 4000; n++) begin
      bit lv = $urandom_range(0, 3) != 0;
      bit uv = $urandom_range(0, 1) == 1;
      bit fl = $urandom_range(0, 63) == 0;
      step(lv, mk($urandom_range(1, 3), $urandom_range(0, 15)), uv,
           mk($urandom_range(1, 3), $urandom_range(0, 15)),
           {$urandom_range(0, 32'hffff), 2'b00}, 1'($urandom_range(0, 1)),
           2'($urandom_range(0, 3)), fl, "");
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule